// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8051-style external memory bus from the oscillator clock: an active-high address-latch strobe and an active-low program-fetch read strobe. One machine cycle is twelve oscillator clocks. It is split into two equal halves, or slots, of six clocks each, and each slot carries one address-latch pulse and one fetch-read window. The address-latch strobe therefore runs at one sixth of the oscillator rate, and the fetch strobe is asserted twice per machine cycle while code is fetched from external memory.

The core's sequencer gives four per-cycle qualifiers: the cycle is an external data transfer, the cycle is a code-table read, code is executed from external memory, and the address-latch strobe is turned off by software. These qualifiers are captured once, at the start of each machine cycle. In a data-transfer cycle the second address-latch pulse and both fetch windows are dropped, which frees the bus for the data transfer. When the latch strobe is turned off, it is parked high, except in data-transfer or table-read cycles. External execution always overrides the turn-off.

A synchronous reset puts the cycle position in a fixed state. The first clock edge after reset is released therefore starts a machine cycle at position zero.

Top module: `ext_bus_strobe`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next outputs are `ale_o` = 0 and `psen_n_o` = 1.
- R2: Machine-cycle position p (0..11) is p = n mod 12, where n counts rising edges from the first edge after reset is released. With the strobe enabled and no data transfer, `ale_o` is 1 at positions 0, 1, 6 and 7 and 0 elsewhere.
- R3: In a cycle flagged as an external data transfer (`data_cyc_i` = 1) with the strobe enabled, the pulse at positions 0 and 1 is kept and the pulse at positions 6 and 7 is dropped (`ale_o` = 0).
- R4: With `ext_fetch_i` = 1 and no data transfer, `psen_n_o` is 0 at positions 3, 4, 5, 9, 10 and 11 and 1 elsewhere.
- R5: In a data-transfer cycle, `psen_n_o` stays 1 at all positions, including when `ext_fetch_i` = 1.
- R6: With `ext_fetch_i` = 0, `psen_n_o` stays 1 at all positions.
- R7: With `ale_off_i` = 1, `ext_fetch_i` = 0, `data_cyc_i` = 0 and `table_rd_i` = 0, `ale_o` is held at 1 for the whole machine cycle.
- R8: With `ale_off_i` = 1, a cycle flagged by `data_cyc_i` or `table_rd_i` produces the ALE pattern of R2/R3.
- R9: With `ext_fetch_i` = 1, `ale_off_i` has no effect on `ale_o`.
- R10: The four qualifier inputs are sampled only at the edge that starts position 0. A change at any other position affects outputs only from the next machine cycle.
- R11: `ale_o` = 1 and `psen_n_o` = 0 never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| data_cyc_i | input | 1 | Machine cycle is an external data transfer |
| table_rd_i | input | 1 | Machine cycle is a code-table read |
| ext_fetch_i | input | 1 | Code is executed from external memory |
| ale_off_i | input | 1 | Software turn-off of the address-latch strobe |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-fetch read strobe, active low |

## Verification
Both strobes are registered and their state settles one rising edge after the position it belongs to. The qualifiers for a machine cycle must therefore be valid at the edge that closes position 11 of the previous cycle. The bench changes inputs only at falling edges. It applies a cycle's qualifiers at the falling edge after position 11 has been checked, then samples both strobes at the falling edge after every rising edge, compared with position p = n mod 12. The mid-cycle change test alters the qualifiers after position 4 has been sampled and expects the old pattern up to position 11 and the new one only from the next position 0. The reset test checks outputs one edge after reset is raised, and restarts at position 0 on the first edge after release.

// File: rtl/ext_bus_strobe_pkg.sv
package ext_bus_strobe_pkg;

    // Qualifiers captured once per machine cycle
    typedef struct packed {
        logic data_cyc;   // external data transfer in this cycle
        logic table_rd;   // code-table read in this cycle
        logic ext_fetch;  // executing from external code memory
        logic ale_off;    // software turn-off of the latch strobe
    } cyc_flags_t;

    localparam cyc_flags_t FLAGS_IDLE = '{data_cyc: 1'b0, table_rd: 1'b0,
                                          ext_fetch: 1'b0, ale_off: 1'b0};

endpackage

// File: rtl/ebs_phase_ctr.sv
module ebs_phase_ctr #(
    parameter int SLOT_LEN = 6,
    parameter int SLOTS    = 2,
    localparam int OFF_W   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [OFF_W-1:0]  nxt_off_o,
    output logic [SLOT_W-1:0] nxt_slot_o,
    output logic              nxt_start_o
);
    localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(SLOT_LEN - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [SLOT_W-1:0] slot;
    } pos_t;

    pos_t pos_d, pos_q;
    logic off_wrap;

    always_comb begin
        pos_d    = pos_q;
        off_wrap = (pos_q.off == OFF_LAST);
        if (off_wrap) begin
            pos_d.off = '0;
            if (pos_q.slot == SLOT_LAST) begin
                pos_d.slot = '0;
            end else begin
                pos_d.slot = pos_q.slot + 1'b1;
            end
        end else begin
            pos_d.off = pos_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '{off: OFF_LAST, slot: SLOT_LAST};
        end else begin
            pos_q <= pos_d;
        end
    end

    assign nxt_off_o   = pos_d.off;
    assign nxt_slot_o  = pos_d.slot;
    assign nxt_start_o = off_wrap && (pos_q.slot == SLOT_LAST);

endmodule

// File: rtl/ebs_cyc_latch.sv
module ebs_cyc_latch
    import ext_bus_strobe_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       nxt_start_i,
    input  cyc_flags_t flags_i,
    output cyc_flags_t flags_nxt_o
);
    cyc_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (nxt_start_i) begin
            flags_d = flags_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flags_q <= FLAGS_IDLE;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_nxt_o = flags_d;

endmodule

// File: rtl/ebs_ale_gen.sv
module ebs_ale_gen
    import ext_bus_strobe_pkg::*;
#(
    parameter int SLOT_LEN  = 6,
    parameter int SLOTS     = 2,
    parameter int ALE_HIGH  = 2,
    parameter int SKIP_SLOT = 1,
    localparam int OFF_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [OFF_W-1:0]  nxt_off_i,
    input  logic [SLOT_W-1:0] nxt_slot_i,
    input  cyc_flags_t        flags_nxt_i,
    output logic              ale_o
);
    typedef struct packed {
        logic ale;
    } ale_st_t;

    ale_st_t st_d, st_q;
    logic    enabled, in_pulse, skipped;

    always_comb begin
        st_d     = st_q;
        enabled  = !flags_nxt_i.ale_off || flags_nxt_i.ext_fetch
                   || flags_nxt_i.data_cyc || flags_nxt_i.table_rd;
        in_pulse = (int'(nxt_off_i) < ALE_HIGH);
        skipped  = flags_nxt_i.data_cyc && (int'(nxt_slot_i) == SKIP_SLOT);
        if (!enabled) begin
            st_d.ale = 1'b1;
        end else begin
            st_d.ale = in_pulse && !skipped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{ale: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ale_o = st_q.ale;

endmodule

// File: rtl/ebs_psen_gen.sv
module ebs_psen_gen
    import ext_bus_strobe_pkg::*;
#(
    parameter int SLOT_LEN  = 6,
    parameter int PSEN_LEAD = 3,
    parameter int PSEN_LOW  = 3,
    localparam int OFF_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [OFF_W-1:0] nxt_off_i,
    input  cyc_flags_t       flags_nxt_i,
    output logic             psen_n_o
);
    typedef struct packed {
        logic psen_n;
    } psen_st_t;

    psen_st_t st_d, st_q;
    logic     in_win, fetching;

    always_comb begin
        st_d     = st_q;
        in_win   = (int'(nxt_off_i) >= PSEN_LEAD)
                   && (int'(nxt_off_i) < PSEN_LEAD + PSEN_LOW);
        fetching = flags_nxt_i.ext_fetch && !flags_nxt_i.data_cyc;
        st_d.psen_n = !(fetching && in_win);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{psen_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign psen_n_o = st_q.psen_n;

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
    import ext_bus_strobe_pkg::*;
#(
    parameter int OSC_PER_MCYC = 12,
    parameter int SLOTS        = 2,
    parameter int ALE_HIGH     = 2,
    parameter int SKIP_SLOT    = 1,
    parameter int PSEN_LEAD    = 3,
    parameter int PSEN_LOW     = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic data_cyc_i,
    input  logic table_rd_i,
    input  logic ext_fetch_i,
    input  logic ale_off_i,
    output logic ale_o,
    output logic psen_n_o
);
    localparam int SLOT_LEN = OSC_PER_MCYC / SLOTS;
    localparam int OFF_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [OFF_W-1:0]  nxt_off;
    logic [SLOT_W-1:0] nxt_slot;
    logic              nxt_start;
    cyc_flags_t        flags_in, flags_nxt;

    assign flags_in = '{data_cyc: data_cyc_i, table_rd: table_rd_i,
                        ext_fetch: ext_fetch_i, ale_off: ale_off_i};

    ebs_phase_ctr #(.SLOT_LEN(SLOT_LEN), .SLOTS(SLOTS)) u_ctr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .nxt_off_o  (nxt_off),
        .nxt_slot_o (nxt_slot),
        .nxt_start_o(nxt_start)
    );

    ebs_cyc_latch u_flags (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .nxt_start_i(nxt_start),
        .flags_i    (flags_in),
        .flags_nxt_o(flags_nxt)
    );

    ebs_ale_gen #(
        .SLOT_LEN (SLOT_LEN),
        .SLOTS    (SLOTS),
        .ALE_HIGH (ALE_HIGH),
        .SKIP_SLOT(SKIP_SLOT)
    ) u_ale (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .nxt_off_i  (nxt_off),
        .nxt_slot_i (nxt_slot),
        .flags_nxt_i(flags_nxt),
        .ale_o      (ale_o)
    );

    ebs_psen_gen #(
        .SLOT_LEN (SLOT_LEN),
        .PSEN_LEAD(PSEN_LEAD),
        .PSEN_LOW (PSEN_LOW)
    ) u_psen (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .nxt_off_i  (nxt_off),
        .flags_nxt_i(flags_nxt),
        .psen_n_o   (psen_n)
    );

    logic psen_n;
    assign psen_n_o = psen_n;

endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk #(
    parameter int SLOT_LEN  = 6,
    parameter int ALE_HIGH  = 2,
    parameter int PSEN_LEAD = 3,
    parameter int PSEN_LOW  = 3
) (
    input logic clk_i,
    input logic rst_i,
    input logic ale_o,
    input logic psen_n_o
);
    localparam int OFF_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int RUN_W = $clog2(SLOT_LEN + 2);

    logic [OFF_W-1:0] off_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            off_q <= OFF_W'(SLOT_LEN - 1);
        end else if (int'(off_q) == SLOT_LEN - 1) begin
            off_q <= '0;
        end else begin
            off_q <= off_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || psen_n_o) begin
            run_q <= '0;
        end else if (int'(run_q) <= SLOT_LEN) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk_i)
        rst_i |=> (!ale_o && psen_n_o));

    // R2
    ale_edge_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(ale_o) |-> (off_q == '0 || int'(off_q) == ALE_HIGH));

    // R4
    psen_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !psen_n_o |-> (int'(off_q) >= PSEN_LEAD));

    // R4
    psen_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(run_q) <= PSEN_LOW);

    // R11
    strobe_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ale_o && !psen_n_o));

endmodule

bind ext_bus_strobe ext_bus_strobe_chk #(
    .SLOT_LEN (OSC_PER_MCYC / SLOTS),
    .ALE_HIGH (ALE_HIGH),
    .PSEN_LEAD(PSEN_LEAD),
    .PSEN_LOW (PSEN_LOW)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ale_o   (ale_o),
    .psen_n_o(psen_n_o)
);

// File: tb/ext_bus_strobe_bench.sv
`timescale 1ns/1ps
module ext_bus_strobe_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_cyc = 1'b0, table_rd = 1'b0, ext_fetch = 1'b0, ale_off = 1'b0;
    logic ale, psen_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ext_bus_strobe u_ext_bus_strobe (
        .clk_i      (clk),
        .rst_i      (rst),
        .data_cyc_i (data_cyc),
        .table_rd_i (table_rd),
        .ext_fetch_i(ext_fetch),
        .ale_off_i  (ale_off),
        .ale_o      (ale),
        .psen_n_o   (psen_n)
    );

    // Vector bits: {data_cyc, table_rd, ext_fetch, ale_off}
    localparam int NVEC = 12;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0000, 4'b0010, 4'b1010, 4'b1000, 4'b0001, 4'b0101,
        4'b1001, 4'b0011, 4'b1011, 4'b0100, 4'b0010, 4'b0001
    };

    function automatic logic exp_ale(int p, logic [3:0] v);
        logic en;
        en = !v[0] || v[1] || v[3] || v[2];
        if (!en) return 1'b1;
        if (v[3] && p >= 6) return 1'b0;
        return (p % 6) < 2;
    endfunction

    function automatic logic exp_psen_n(int p, logic [3:0] v);
        return !(v[1] && !v[3] && (p % 6) >= 3);
    endfunction

    function automatic string ale_tag(logic [3:0] v);
        if (v[0] && !v[1] && !v[2] && !v[3]) return "R7";
        if (v[0] && v[1]) return "R9";
        if (v[0]) return "R8";
        if (v[3]) return "R3";
        return "R2";
    endfunction

    function automatic string psen_tag(logic [3:0] v);
        if (v[3]) return "R5";
        if (v[1]) return "R4";
        return "R6";
    endfunction

    task automatic chk(logic act, logic exp, string tag, int p);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos %0d: actual %b expected %b", tag, p, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] v);
        {data_cyc, table_rd, ext_fetch, ale_off} = v;
    endtask

    task automatic run_cycle(logic [3:0] v, string tag_a, string tag_p);
        for (int p = 0; p < 12; p++) begin
            @(posedge clk);
            @(negedge clk);
            chk(ale, exp_ale(p, v), tag_a, p);
            chk(psen_n, exp_psen_n(p, v), tag_p, p);
            chk(ale && !psen_n, 1'b0, "R11", p);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ale, 1'b0, "R1", 0);
        chk(psen_n, 1'b1, "R1", 0);

        apply(VEC[0]);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            run_cycle(VEC[i], ale_tag(VEC[i]), psen_tag(VEC[i]));
        end

        // R10: qualifiers changed mid-cycle act only from the next cycle
        apply(4'b0000);
        for (int p = 0; p < 12; p++) begin
            @(posedge clk);
            @(negedge clk);
            chk(ale, exp_ale(p, 4'b0000), "R10", p);
            chk(psen_n, exp_psen_n(p, 4'b0000), "R10", p);
            if (p == 4) apply(4'b0011);
            if (p == 8) apply(4'b0010);
        end
        run_cycle(4'b0010, "R10", "R10");

        // R1: reset in the middle of a cycle, then restart at position 0
        apply(4'b0010);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(ale, 1'b0, "R1", 0);
        chk(psen_n, 1'b1, "R1", 0);
        rst = 1'b0;
        run_cycle(4'b0010, "R2", "R4");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule